// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that exposes a bank of 256 eight-bit registers to a bus controller. It oversamples SCL and SDA with the system clock and detects START, repeated START and STOP on the synchronised lines. It then decodes the 7-bit device address and the direction bit, and answers on SDA through an open-drain output enable. The enable pulls the line low when set.

A write transaction carries a register-pointer byte followed by data bytes. Each data byte is stored at the pointer, and the pointer then advances, so a controller that keeps clocking without a STOP fills consecutive registers. A read transaction returns the register under the pointer. The usual way to set up a read is a pointer-setting write, then a repeated START, then the device address with the read bit. Each controller ACK after a returned byte makes the target send the next register. A controller NACK ends the burst.

The device address comes from a strap input. Every pin is a plain level. There is no clock stretching, so the target never slows the controller.

Top module: `i2c_regbank_target`

## Requirements
- R1: The first byte after START is matched MSB-first against `dev_addr_strap` (bits 7..1), and bit 0 selects the direction (0 write, 1 read). On a match the target pulls SDA low for the whole ninth clock.
- R2: On an address mismatch the target never pulls SDA low and leaves the registers unchanged until the next START or STOP.
- R3: In a write, the byte after the address loads the register pointer and is acknowledged. The next byte is stored at that pointer and is acknowledged.
- R4: Each further data byte written without a STOP goes to the previous pointer plus one.
- R5: A read returns the register at the current pointer, including the pointer set by a write that ended in a repeated START.
- R6: While the controller ACKs a read byte, the target sends the next register. After a controller NACK the target releases SDA and drives nothing on later clocks.
- R7: The register pointer wraps from 0xFF to 0x00 when it advances, on both writes and reads.
- R8: A START or STOP in the middle of a byte abandons that byte, and no register is written.
- R9: The SDA enable changes only after an SCL falling edge (or on START/STOP, where it is released). Received bits are taken on SCL rising edges.
- R10: After reset all registers read 0x00 and SDA is released.
- R11: STOP releases SDA and returns the target to idle. A repeated START is accepted at any point in a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_strap | input | 7 | Device address this target answers to |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |

## Verification
On a read, a single SCL falling edge both ends the target's address ACK and starts driving bit 7 of the first data byte. The same edge also advances the pointer, which may wrap. The bench provokes this by reading registers whose top bit is 0, where the line must stay low without a glitch, and registers whose top bit is 1, where the line must let go exactly then. It also reads across the 0xFF to 0x00 boundary. It judges the result by sampling SDA at both ends of every SCL high phase and comparing the bytes against a model of the register bank.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_TXLD
  } tgt_state_e;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_PTR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (wr_en && wr_addr == AW'(g))         mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_regbank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] dev_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] ptr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tgt_state_e    state;
  byte_kind_e    kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          is_read;
  logic [DW-1:0] rx_byte;
  logic          byte_done;

  assign rx_byte   = {shreg[DW-2:0], sda_s};
  assign byte_done = (state == ST_RX) && scl_rise && (cnt == LAST);
  assign wr_en     = byte_done && (kind == BK_DATA);
  assign wr_data   = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= BK_DEV;
      cnt     <= '0;
      shreg   <= '0;
      is_read <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      kind    <= BK_DEV;
      cnt     <= '0;
      is_read <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: if (scl_rise) begin
          shreg <= rx_byte;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            cnt <= '0;
            case (kind)
              BK_DEV: begin
                if (rx_byte[DW-1:1] == dev_addr) begin
                  is_read <= rx_byte[0];
                  state   <= ST_ACKW;
                end else begin
                  state <= ST_IDLE;
                end
              end
              BK_PTR: begin
                ptr   <= rx_byte;
                state <= ST_ACKW;
              end
              default: begin
                ptr   <= ptr + 1'b1;
                state <= ST_ACKW;
              end
            endcase
          end
        end
        ST_ACKW: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          cnt <= '0;
          if (is_read) begin
            shreg  <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            ptr    <= ptr + 1'b1;
            state  <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_RX;
            kind   <= (kind == BK_DEV) ? BK_PTR : BK_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == LAST) begin
            sda_oe <= 1'b0;
            state  <= ST_MACK;
          end else begin
            cnt    <= cnt + 1'b1;
            shreg  <= {shreg[DW-2:0], 1'b0};
            sda_oe <= ~shreg[DW-2];
          end
        end
        ST_MACK: if (scl_rise) begin
          state <= sda_s ? ST_IDLE : ST_TXLD;
        end
        ST_TXLD: if (scl_fall) begin
          cnt    <= '0;
          shreg  <= rd_data;
          sda_oe <= ~rd_data[DW-1];
          ptr    <= ptr + 1'b1;
          state  <= ST_TX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] dev_addr_strap,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_W-1:0] ptr, wr_data, rd_data;
  logic wr_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr_strap), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  i2c_reg_array #(.DW(DATA_W), .AW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic [DATA_W-1:0] ptr
);
  // R9
  oe_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R9
  oe_fall_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R7
  ptr_step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(ptr) + DATA_W'(1));
endmodule

bind i2c_regbank_target i2c_regbank_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;
  localparam int Q = 8;
  localparam logic [6:0] MY_ADDR = 7'h4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];
  logic [7:0] mptr = 8'h00;
  logic [7:0] wbuf [8];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_target u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr_strap(MY_ADDR),
    .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s1, s2;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(1);
      s1 = sda_line; tick(2 * Q - 1);
      s2 = sda_line;
      chk(s1 == s2, "R9 stable during SCL high", s2, s1);
      b[i] = s1;
      scl_m = 1'b0;
    end
    tick(Q);
    send_bit(~mack);
    sda_m = 1'b1;
  endtask

  // write n bytes from wbuf starting at pointer p
  task automatic wr_burst(input logic [7:0] p, input int n);
    logic a;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk(a, "R1 address ACK (write)", a, 1);
    send_byte(p, a);
    chk(a, "R3 pointer ACK", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(a, "R4 data ACK", a, 1);
      model[8'(p + i)] = wbuf[i];
    end
    mptr = 8'(p + n);
    bus_stop();
  endtask

  // set pointer, repeated START, read n bytes (NACK last)
  task automatic rd_burst(input logic [7:0] p, input int n, input bit setp);
    logic a;
    logic [7:0] d;
    bus_start();
    if (setp) begin
      send_byte({MY_ADDR, 1'b0}, a);
      chk(a, "R1 address ACK (pointer set)", a, 1);
      send_byte(p, a);
      chk(a, "R3 pointer ACK", a, 1);
      bus_start();
      mptr = p;
    end
    send_byte({MY_ADDR, 1'b1}, a);
    chk(a, "R1 address ACK (read)", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == model[mptr], "R5/R6 read data", d, model[mptr]);
      mptr = mptr + 8'd1;
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R11 released after STOP", sda_oe, 0);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic lo;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    void'($urandom(32'h5EED));
    tick(4);
    chk(sda_oe == 1'b0, "R10 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(4);
    chk(sda_oe == 1'b0, "R10 SDA released after reset", sda_oe, 0);
    // R10: registers read zero after reset, reading from the default pointer
    rd_burst(8'h00, 3, 1'b0);
    rd_burst(8'hC3, 2, 1'b1);

    // R3 single write then read back; MSB 1 and MSB 0 values
    wbuf[0] = 8'hA5; wr_burst(8'h10, 1);
    wbuf[0] = 8'h3C; wr_burst(8'h11, 1);
    rd_burst(8'h10, 2, 1'b1);

    // R4 burst write
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h81 + 8'(i * 17));
    wr_burst(8'h20, 4);
    rd_burst(8'h20, 4, 1'b1);

    // R7 wrap on write and on read
    wbuf[0] = 8'h11; wbuf[1] = 8'h7E; wbuf[2] = 8'hE7;
    wr_burst(8'hFE, 3);
    rd_burst(8'hFF, 2, 1'b1);
    chk(model[0] == 8'hE7, "R7 wrap model", model[0], 8'hE7);

    // R5 read from current pointer without setting it
    rd_burst(8'h00, 2, 1'b0);

    // R2 mismatched address: no ACK, no write
    bus_start();
    send_byte({MY_ADDR ^ 7'h01, 1'b0}, a);
    chk(!a, "R2 no ACK on mismatch", a, 0);
    send_byte(8'h10, a);
    chk(!a, "R2 ignored pointer byte", a, 0);
    send_byte(8'hFF, a);
    chk(!a, "R2 ignored data byte", a, 0);
    bus_stop();
    rd_burst(8'h10, 1, 1'b1);

    // R8 STOP mid-byte aborts the data byte
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    send_byte(8'h40, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    rd_burst(8'h40, 1, 1'b1);
    chk(model[8'h40] == 8'h00, "R8 STOP abort model", model[8'h40], 0);

    // R8 repeated START mid-byte aborts, then a fresh read (R11)
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    send_byte(8'h41, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a);
    chk(a, "R11 repeated START mid-byte accepted", a, 1);
    recv_byte(1'b0, d);
    chk(d == 8'h00, "R8 START abort left register", d, 0);
    bus_stop();

    // R6 after NACK target drives nothing on further clocks
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    send_byte(8'h20, a);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a);
    recv_byte(1'b0, d);
    chk(d == model[8'h20], "R6 last byte before NACK", d, model[8'h20]);
    lo = 1'b0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      if (!sda_line) lo = 1'b1;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    chk(!lo, "R6 silent after NACK", lo, 0);
    bus_stop();

    // Random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_burst(p, n);
      end else begin
        rd_burst(p, n, 1'b1);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule